// File: doc/BRIEF.md
# Dirty-Page Log Producer Register

This block holds the producer state for a hardware log of dirty memory granules that is kept in a circular buffer. One 64-bit register packs two fields: a write index that names the log slot to be filled next, and a sticky fault code that records why a log write failed. A log-writer agent reports the result of each entry it tries to commit through a valid/ready event port. A successful commit advances the index, which wraps at a power-of-two buffer size. A failed commit latches a fault code. While that code is non-zero, further entries are treated as lost and the index stays frozen.

Software reads the whole register at all times through a flat read bus. It can overwrite the index and fault fields together with a single-cycle write strobe. Writing zero to the fault field resumes logging.

Back-pressure rule: `ev_ready` is low in any cycle in which software writes. An event is taken only in a cycle where `ev_valid` and `ev_ready` are both high. A producer must hold `ev_valid` and `ev_kind` steady until the event is taken. So a software write always wins a collision, and the held event is applied in the first cycle after the write. It is then evaluated against the state that software just wrote.

Top module: `dlog_prod_reg`

## Requirements
- R1: After reset, `sw_rdata` reads as all zeros.
- R2: Bits [63:32] and [25:19] of `sw_rdata` always read zero, whatever was written.
- R3: When a taken event has kind 2'b00 (success) and the fault field is zero, the index in `sw_rdata[18:0]` increases by one in the cycle after the event is taken.
- R4: The index wraps from 2^DEPTH_LOG2-1 to zero; index bits at and above DEPTH_LOG2 always read zero.
- R5: When a taken event has kind 2'b01 (external abort) or 2'b11 (reserved) and the fault field is zero, the fault field `sw_rdata[31:26]` becomes 6'b010000 and the index does not change.
- R6: When a taken event has kind 2'b10 (granule-protection fault) and the fault field is zero, the fault field becomes 6'b101000 if REALM_EN is 1, and 6'b010000 if REALM_EN is 0. The index does not change in either case.
- R7: While the fault field is non-zero, taken events change neither the fault field nor the index.
- R8: A software write (`sw_wr_en` high) loads `sw_wdata[31:26]` into the fault field and the low DEPTH_LOG2 bits of `sw_wdata` into the index, in the next cycle. Writing zero to the fault field clears it.
- R9: `ev_ready` is low exactly in cycles where `sw_wr_en` is high. An event held across a software write is applied after the write completes, and is evaluated against the newly written state.
- R10: `wr_index` always equals `sw_rdata[18:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Packed register value |
| ev_valid | input | 1 | Log-writer event valid |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_kind | input | 2 | Event result: 00 success, 01 external abort, 10 granule-protection fault, 11 reserved (handled as an abort) |
| wr_index | output | 19 | Index of the next log slot to write |

## Verification
The assertions assume that reset is applied before the first event. They also assume that `ev_kind` is a known value whenever `ev_valid` is high. The sticky and no-advance properties assume that only a software write may change the fault field once it is set. The bench drives every input on the falling clock edge and holds each event until it has been taken. It releases reset before any stimulus. Every write it issues goes through `sw_wr_en`, so the assumed conditions always hold.

// File: rtl/dlog_pkg.sv
package dlog_pkg;
  localparam int IDX_FIELD_W = 19;
  localparam int FSC_LSB     = 26;
  localparam int FSC_W       = 6;
  localparam int RSVD_LO_W   = FSC_LSB - IDX_FIELD_W;

  typedef enum logic [1:0] {
    EV_OK  = 2'b00,
    EV_EXT = 2'b01,
    EV_GPF = 2'b10,
    EV_RSV = 2'b11
  } ev_kind_e;

  localparam logic [FSC_W-1:0] FSC_NONE = 6'b000000;
  localparam logic [FSC_W-1:0] FSC_EXT  = 6'b010000;
  localparam logic [FSC_W-1:0] FSC_GPF  = 6'b101000;
endpackage

// File: rtl/dlog_index_ctr.sv
module dlog_index_ctr #(
  parameter int DEPTH_LOG2 = 19
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DEPTH_LOG2-1:0] load_val,
  input  logic                  step,
  output logic [DEPTH_LOG2-1:0] idx
);
  // Power-of-two depth: natural overflow implements the wrap.
  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= load_val;
    else if (step) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/dlog_fault_trap.sv
module dlog_fault_trap
  import dlog_pkg::*;
#(
  parameter bit REALM_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FSC_W-1:0] load_val,
  input  logic             hit,
  input  ev_kind_e         kind,
  output logic [FSC_W-1:0] code,
  output logic             pending
);
  logic [FSC_W-1:0] new_code;

  generate
    if (REALM_EN) begin : g_realm
      always_comb new_code = (kind == EV_GPF) ? FSC_GPF : FSC_EXT;
    end else begin : g_plain
      always_comb new_code = FSC_EXT;
    end
  endgenerate

  assign pending = (code != FSC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)               code <= FSC_NONE;
    else if (load)            code <= load_val;
    else if (hit && !pending) code <= new_code;
  end
endmodule

// File: rtl/dlog_reg_pack.sv
module dlog_reg_pack
  import dlog_pkg::*;
#(
  parameter int DEPTH_LOG2 = 19
) (
  input  logic [DEPTH_LOG2-1:0] idx,
  input  logic [FSC_W-1:0]      code,
  output logic [63:0]           word
);
  logic [IDX_FIELD_W-1:0] idx_field;

  generate
    if (DEPTH_LOG2 < IDX_FIELD_W) begin : g_pad
      assign idx_field = {{(IDX_FIELD_W-DEPTH_LOG2){1'b0}}, idx};
    end else begin : g_full
      assign idx_field = idx;
    end
  endgenerate

  assign word = {32'b0, code, {RSVD_LO_W{1'b0}}, idx_field};
endmodule

// File: rtl/dlog_prod_reg.sv
module dlog_prod_reg
  import dlog_pkg::*;
#(
  parameter int DEPTH_LOG2 = 19,
  parameter bit REALM_EN   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [63:0] sw_wdata,
  output logic [63:0] sw_rdata,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [1:0]  ev_kind,
  output logic [18:0] wr_index
);
  logic                  taken;
  logic                  pending;
  logic                  step;
  logic                  hit;
  logic [DEPTH_LOG2-1:0] idx;
  logic [FSC_W-1:0]      code;
  ev_kind_e              kind;

  assign kind     = ev_kind_e'(ev_kind);
  assign ev_ready = !sw_wr_en;
  assign taken    = ev_valid && ev_ready;
  assign step     = taken && (kind == EV_OK) && !pending;
  assign hit      = taken && (kind != EV_OK);

  dlog_index_ctr #(.DEPTH_LOG2(DEPTH_LOG2)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sw_wr_en),
    .load_val (sw_wdata[DEPTH_LOG2-1:0]),
    .step     (step),
    .idx      (idx)
  );

  dlog_fault_trap #(.REALM_EN(REALM_EN)) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sw_wr_en),
    .load_val (sw_wdata[FSC_LSB +: FSC_W]),
    .hit      (hit),
    .kind     (kind),
    .code     (code),
    .pending  (pending)
  );

  dlog_reg_pack #(.DEPTH_LOG2(DEPTH_LOG2)) u_pack (
    .idx  (idx),
    .code (code),
    .word (sw_rdata)
  );

  assign wr_index = sw_rdata[IDX_FIELD_W-1:0];
endmodule

// File: rtl/dlog_prod_chk.sv
module dlog_prod_chk #(
  parameter int DEPTH_LOG2 = 19
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic [63:0] sw_wdata,
  input logic [63:0] sw_rdata,
  input logic        ev_valid,
  input logic        ev_ready,
  input logic [1:0]  ev_kind
);
  localparam logic [18:0] IMASK = 19'((20'(1) << DEPTH_LOG2) - 20'(1));

  logic [18:0] idx;
  logic [5:0]  fsc;
  logic        tk;
  assign idx = sw_rdata[18:0];
  assign fsc = sw_rdata[31:26];
  assign tk  = ev_valid && ev_ready;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[63:32] == 32'b0 && sw_rdata[25:19] == 7'b0);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tk && ev_kind == 2'b00 && fsc == 6'b0 |=> idx == ((($past(idx)) + 19'd1) & IMASK));

  a_r5_fault_holds_index: assert property (@(posedge clk) disable iff (!rst_n)
    tk && ev_kind != 2'b00 |=> idx == $past(idx));

  a_r7_sticky_code: assert property (@(posedge clk) disable iff (!rst_n)
    fsc != 6'b0 && !sw_wr_en |=> fsc == $past(fsc));

  a_r7_frozen_index: assert property (@(posedge clk) disable iff (!rst_n)
    fsc != 6'b0 && !sw_wr_en |=> $stable(idx));

  a_r8_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> fsc == $past(sw_wdata[31:26]) && idx == ($past(sw_wdata[18:0]) & IMASK));

  a_r9_no_take_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |-> !ev_ready);
endmodule

bind dlog_prod_reg dlog_prod_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sw_wr_en (sw_wr_en),
  .sw_wdata (sw_wdata),
  .sw_rdata (sw_rdata),
  .ev_valid (ev_valid),
  .ev_ready (ev_ready),
  .ev_kind  (ev_kind)
);

// File: tb/dlog_prod_reg_tb_top.sv
module dlog_prod_reg_tb_top;
  localparam int DL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [63:0] sw_wdata = '0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = 2'b00;
  logic [63:0] rdata, rdata_nr;
  logic        ready, ready_nr;
  logic [18:0] widx, widx_nr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dlog_prod_reg #(.DEPTH_LOG2(DL), .REALM_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
    .sw_rdata(rdata), .ev_valid(ev_valid), .ev_ready(ready),
    .ev_kind(ev_kind), .wr_index(widx));

  dlog_prod_reg #(.DEPTH_LOG2(DL), .REALM_EN(1'b0)) dut_nr_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
    .sw_rdata(rdata_nr), .ev_valid(ev_valid), .ev_ready(ready_nr),
    .ev_kind(ev_kind), .wr_index(widx_nr));

  function automatic logic [63:0] pack(input logic [5:0] c, input logic [18:0] i);
    return {32'b0, c, 7'b0, i};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [63:0] d);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wdata = d;
    @(negedge clk);
    sw_wr_en = 1'b0; sw_wdata = '0;
  endtask

  task automatic send(input logic [1:0] k);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 reset value", rdata, 64'b0);
    chk("R10 wr_index at reset", {45'b0, widx}, 64'b0);
  endtask

  task automatic t_advance;
    for (int n = 0; n < 3; n++) send(2'b00);
    chk("R3 three successes", rdata, pack(6'd0, 19'd3));
    chk("R10 wr_index tracks", {45'b0, widx}, 64'd3);
  endtask

  task automatic t_wrap;
    sw_write(pack(6'd0, 19'd14));
    send(2'b00);
    chk("R4 reach top", rdata, pack(6'd0, 19'd15));
    send(2'b00);
    chk("R4 wrap to zero", rdata, pack(6'd0, 19'd0));
  endtask

  task automatic t_reserved;
    sw_write(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 R4 reserved and high index bits read zero", rdata, pack(6'h3F, 19'hF));
    sw_write(64'b0);
    chk("R8 write zero clears", rdata, 64'b0);
  endtask

  task automatic t_ext_abort;
    sw_write(pack(6'd0, 19'd7));
    send(2'b01);
    chk("R5 external abort code, index held", rdata, pack(6'b010000, 19'd7));
    sw_write(pack(6'd0, 19'd7));
    send(2'b11);
    chk("R5 reserved kind treated as abort", rdata, pack(6'b010000, 19'd7));
  endtask

  task automatic t_gpf;
    sw_write(pack(6'd0, 19'd2));
    send(2'b10);
    chk("R6 granule fault with realm enabled", rdata, pack(6'b101000, 19'd2));
    chk("R6 granule fault with realm disabled", rdata_nr, pack(6'b010000, 19'd2));
  endtask

  task automatic t_sticky;
    sw_write(pack(6'd0, 19'd9));
    send(2'b01);
    send(2'b10);
    chk("R7 later fault keeps first code", rdata, pack(6'b010000, 19'd9));
    send(2'b00);
    send(2'b00);
    chk("R7 success does not advance while pending", rdata, pack(6'b010000, 19'd9));
    sw_write(pack(6'd0, 19'd9));
    send(2'b00);
    chk("R8 logging resumes after clear", rdata, pack(6'd0, 19'd10));
  endtask

  task automatic t_collision;
    sw_write(pack(6'd0, 19'd1));
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wdata = pack(6'd0, 19'd5);
    ev_valid = 1'b1; ev_kind = 2'b00;
    #1;
    chk("R9 ready low during write", {63'b0, ready}, 64'd0);
    @(negedge clk);
    chk("R9 software wins collision", rdata, pack(6'd0, 19'd5));
    sw_wr_en = 1'b0; sw_wdata = '0;
    #1;
    chk("R9 ready high after write", {63'b0, ready}, 64'd1);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R9 held event applied after write", rdata, pack(6'd0, 19'd6));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_advance();
    t_wrap();
    t_reserved();
    t_ext_abort();
    t_gpf();
    t_sticky();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule